// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

A bank of four 16-bit up-counting timers that share one 32-bit register window. Software picks a timer with a 2-bit index. Each timer sees one 32-bit word. On a write, the low half sets a hidden reload value and the third byte lane sets the control bits. On a read, the word returns the control bits above the live count. Each timer steps either at a programmable fraction of the system clock or, in count-up mode, once for each overflow of the timer below it. Several timers can then act as one wide counter.

When a counter passes 0xFFFF it takes its reload value again. If its interrupt enable is set, it also sends a one-cycle request on its own bit of `irq_o`, which an external interrupt controller picks up. The reload value reaches the counter only on overflow or when the start bit goes from 0 to 1. A running timer can therefore be given its next period without any disturbance to the count in progress.

Top module: `tmr_bank`

## Requirements
- R1: Control bits 17:16 pick the step rate: 0 steps every clock, 1 every 64, 2 every 256, 3 every 1024. The first step lands exactly that many clock edges after the edge that started the timer.
- R2: In the upper half, bit 23 is start, bit 22 is overflow interrupt enable and bit 18 is count-up mode. Every other bit in 31:16 reads as 0.
- R3: A write to the low half changes only the hidden reload value. The counter itself is not disturbed.
- R4: The counter takes the reload value when the start bit rises, or when it wraps from 0xFFFF. A write that leaves an already-set start bit set does not reload.
- R5: Timer n (n ≥ 1) in count-up mode steps once per overflow of timer n-1 and ignores its rate setting. An overflow can ripple through several timers on the same clock edge.
- R6: With the interrupt enable set, a wrap from 0xFFFF drives `irq_o[n]` high for exactly the one cycle after the overflow edge. With the enable clear, no pulse is sent.
- R7: A read returns {8'h00, control byte, live count}. A stopped timer holds and reads its frozen count.
- R8: Timer 0 ignores count-up mode and always uses its rate setting.
- R9: Strobe bit 0 writes reload bits 7:0, bit 1 writes reload bits 15:8 and bit 2 writes control bits 23:16. Lanes whose strobe is clear keep their old value.
- R10: After a synchronous reset every counter, reload value and control field is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Timer index for read and write |
| bus_wr | input | 1 | Write request this cycle |
| bus_wstrb | input | 3 | Byte-lane strobes: reload low, reload high, control |
| bus_wdata | input | 24 | Write data, bits 23:0 of the timer word |
| bus_rdata | output | 32 | Combinational read of the addressed timer |
| irq_o | output | 4 | One-cycle overflow interrupt request per timer |

## Verification
A write takes effect on the clock edge that samples it, so a start write loads the counter at that same edge, and the read path is combinational from the registers. The bench drives and samples only on falling edges. After a start, it counts N rising edges and then expects reload + floor(N/d), where d is the selected divider. At a boundary such as 63 edges at divide-by-64, no step is expected yet. An overflow request is registered, so the bench looks for it at the falling edge just after the wrapping edge and expects it to be gone one cycle later. Cascade ripple is checked within the same edge, with no added latency.

// File: rtl/tmr_pkg.sv
// Shared widths and control-byte field positions for the timer bank.
// Assumes the control byte is bits 23:16 of a timer word.
package tmr_pkg;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 10;
    localparam int CTRL_W  = 8;
    localparam int WR_W    = CNT_W + CTRL_W;

    // Field positions inside the control byte (word bit = position + 16)
    localparam int C_START = 7;
    localparam int C_IEN   = 6;
    localparam int C_CASC  = 2;
    localparam int C_PSHI  = 1;
    localparam int C_PSLO  = 0;

    // Bits that exist; all others read back as zero
    localparam logic [CTRL_W-1:0] CTRL_MASK = 8'b1100_0111;

    // Terminal value of the prescaler count for a given rate select
    function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    pre_limit = '0;
            2'd1:    pre_limit = PRE_W'(63);
            2'd2:    pre_limit = PRE_W'(255);
            default: pre_limit = PRE_W'(1023);
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Per-timer clock divider. Gives a one-cycle strobe every 1/64/256/1024
// clocks while running. Restarts from zero when its timer is started.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       strobe
);
    logic [PRE_W-1:0] div_q;

    assign strobe = run && (div_q == pre_limit(sel));

    // Divider count: cleared on reset, on restart, while stopped and at wrap
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run || strobe)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// One 16-bit timer: control byte, hidden reload, counter, overflow request.
// Assumes casc_in is the same-cycle overflow of the timer below (0 for
// timer 0, which never cascades).
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [2:0]        wstrb,
    input  logic [WR_W-1:0]   wdata,
    input  logic              casc_in,
    output logic [CNT_W-1:0]  count_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              ovf_o,
    output logic              irq_o
);
    localparam bit CASC_OK = (IDX != 0);

    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic [CNT_W-1:0]  rld_q, rld_d, cnt_q;
    logic              irq_q, start_rise, pre_stb, step, use_casc;

    // Next control and reload values from the byte lanes
    always_comb begin
        ctrl_d = ctrl_q;
        rld_d  = rld_q;
        if (wr_sel && wstrb[0]) rld_d[7:0]  = wdata[7:0];
        if (wr_sel && wstrb[1]) rld_d[15:8] = wdata[15:8];
        if (wr_sel && wstrb[2]) ctrl_d      = wdata[23:16] & CTRL_MASK;
    end

    assign start_rise = ctrl_d[C_START] && !ctrl_q[C_START];
    assign use_casc   = CASC_OK && ctrl_q[C_CASC];
    assign step       = ctrl_q[C_START] && (use_casc ? casc_in : pre_stb);
    assign ovf_o      = step && (cnt_q == '1);

    tmr_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q[C_START]),
        .restart (start_rise),
        .sel     (ctrl_q[C_PSHI:C_PSLO]),
        .strobe  (pre_stb)
    );

    // Register file: control byte and hidden reload value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rld_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            rld_q  <= rld_d;
        end
    end

    // Counter: load on start rise, reload on wrap, else step by one
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_rise)
            cnt_q <= rld_d;
        else if (ovf_o)
            cnt_q <= rld_q;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // Overflow request, registered for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf_o && ctrl_q[C_IEN];
    end

    assign count_o  = cnt_q;
    assign ctrl_o   = ctrl_q;
    assign reload_o = rld_q;
    assign irq_o    = irq_q;
endmodule

// File: rtl/tmr_bank.sv
// Bank of cascadable timers behind one register window. Reads are
// combinational from the addressed timer; writes apply on the clock edge.
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_TMR = 4,
    localparam int ADDR_W = $clog2(N_TMR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [2:0]        bus_wstrb,
    input  logic [WR_W-1:0]   bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_TMR-1:0]  irq_o
);
    logic [N_TMR-1:0][CNT_W-1:0]  cnt_all, rld_all;
    logic [N_TMR-1:0][CTRL_W-1:0] ctrl_all;
    logic [N_TMR-1:0]             ovf_all, run_all, ien_all, casc_all;

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        logic casc_src;
        if (i == 0) begin : g_head
            assign casc_src = 1'b0;
        end else begin : g_link
            assign casc_src = ovf_all[i-1];
        end

        tmr_channel #(.IDX(i)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (bus_wr && (bus_addr == ADDR_W'(i))),
            .wstrb    (bus_wstrb),
            .wdata    (bus_wdata),
            .casc_in  (casc_src),
            .count_o  (cnt_all[i]),
            .ctrl_o   (ctrl_all[i]),
            .reload_o (rld_all[i]),
            .ovf_o    (ovf_all[i]),
            .irq_o    (irq_o[i])
        );

        assign run_all[i]  = ctrl_all[i][C_START];
        assign ien_all[i]  = ctrl_all[i][C_IEN];
        assign casc_all[i] = ctrl_all[i][C_CASC];
    end

    assign bus_rdata = {8'h00, ctrl_all[bus_addr], cnt_all[bus_addr]};
endmodule

// File: rtl/tmr_bank_chk.sv
// Temporal checks on the timer bank, attached by bind.
module tmr_bank_chk
    import tmr_pkg::*;
#(
    parameter int N_TMR = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_TMR-1:0]           irq_o,
    input logic [N_TMR-1:0][CNT_W-1:0] cnt_all,
    input logic [N_TMR-1:0][CNT_W-1:0] rld_all,
    input logic [N_TMR-1:0]           run_all,
    input logic [N_TMR-1:0]           ien_all,
    input logic [N_TMR-1:0]           casc_all
);
    for (genvar i = 0; i < N_TMR; i++) begin : g_chk
        // R6: a request needs an enabled wrap from 0xFFFF the cycle before
        p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[i] |-> ($past(ien_all[i]) && $past(cnt_all[i]) == 16'hFFFF));

        // R4: a start rise leaves the counter holding the reload value
        p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_all[i]) |-> (cnt_all[i] == rld_all[i]));

        // R7: a timer that stays stopped keeps its count
        p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(!run_all[i]) && !run_all[i]) |-> $stable(cnt_all[i]));

        if (i > 0) begin : g_casc
            // R5: a running count-up timer moves only on an overflow below
            p_casc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (run_all[i] && casc_all[i] && $past(run_all[i] && casc_all[i])
                 && cnt_all[i] != $past(cnt_all[i]))
                |-> ($past(run_all[i-1]) && $past(cnt_all[i-1]) == 16'hFFFF));
        end
    end
endmodule

bind tmr_bank tmr_bank_chk #(.N_TMR(N_TMR)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_o    (irq_o),
    .cnt_all  (cnt_all),
    .rld_all  (rld_all),
    .run_all  (run_all),
    .ien_all  (ien_all),
    .casc_all (casc_all)
);

// File: tb/tmr_bank_tb_top.sv
// Self-checking bench: a vector table for rate and load checks, then
// directed tests for reset, reload, cascade, interrupts and strobes.
module tmr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_wstrb = '0;
    logic [23:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wstrb (bus_wstrb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic [1:0]  tmr;
        logic [15:0] rld;
        logic [1:0]  psel;
        logic [15:0] wait_n;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 16'h1000, 2'd0, 16'd5},
        '{2'd1, 16'h2222, 2'd1, 16'd130},
        '{2'd2, 16'h0ABC, 2'd2, 16'd600},
        '{2'd3, 16'h7000, 2'd3, 16'd2100},
        '{2'd0, 16'h0000, 2'd1, 16'd63},
        '{2'd1, 16'h0000, 2'd1, 16'd64},
        '{2'd3, 16'hFFF0, 2'd0, 16'd15}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [1:0] a, input logic [2:0] s, input logic [23:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wstrb = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL R10 watchdog act=timeout exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R10: reset state
        for (int t = 0; t < 4; t++) begin
            rd(2'(t), v);
            check("R10 reset read", v, 32'h0);
        end
        check("R10 reset irq", {28'h0, irq_o}, 32'h0);

        // R1/R4/R7 vector table: start, wait, read, stop
        for (int k = 0; k < 7; k++) begin
            logic [31:0] ctl, exp;
            int shift;
            ctl   = {8'h00, 8'h80 | {6'h0, VECS[k].psel}, 16'h0};
            shift = (VECS[k].psel == 2'd0) ? 0 : (VECS[k].psel == 2'd1) ? 6 :
                    (VECS[k].psel == 2'd2) ? 8 : 10;
            wr(VECS[k].tmr, 3'b111, ctl[23:0] | {8'h0, VECS[k].rld});
            wait_n(int'(VECS[k].wait_n));
            exp = ctl | 32'(16'(VECS[k].rld + (VECS[k].wait_n >> shift)));
            rd(VECS[k].tmr, v);
            check("R1 rate table", v, exp);
            wr(VECS[k].tmr, 3'b100, 24'h0);
        end

        // R3/R4/R7: reload write, stop, frozen, restart, repeated start
        do_reset();
        wr(2'd0, 3'b111, 24'h800100);
        wait_n(2);
        wr(2'd0, 3'b011, 24'h005555);
        rd(2'd0, v);
        check("R3 reload write keeps count", v, 32'h00800103);
        wr(2'd0, 3'b100, 24'h0);
        rd(2'd0, v);
        check("R7 stop read", v, 32'h00000104);
        wait_n(3);
        rd(2'd0, v);
        check("R7 frozen count", v, 32'h00000104);
        wr(2'd0, 3'b100, 24'h800000);
        rd(2'd0, v);
        check("R4 start rise loads reload", v, 32'h00805555);
        wr(2'd0, 3'b100, 24'h800000);
        rd(2'd0, v);
        check("R4 no reload when already started", v, 32'h00805556);

        // R6: wrap with enable pulses for one cycle
        do_reset();
        wr(2'd0, 3'b111, 24'hC0FFFE);
        wait_n(1);
        check("R6 no irq before wrap", {28'h0, irq_o}, 32'h0);
        wait_n(1);
        check("R6 irq after wrap", {28'h0, irq_o}, 32'h1);
        rd(2'd0, v);
        check("R4 wrap reloads", v, 32'h00C0FFFE);
        wait_n(1);
        check("R6 irq one cycle", {28'h0, irq_o}, 32'h0);

        // R6: wrap without enable raises nothing
        do_reset();
        wr(2'd1, 3'b111, 24'h80FFFF);
        wait_n(3);
        check("R6 disabled irq", {28'h0, irq_o}, 32'h0);

        // R5: ripple through two count-up timers in one edge
        do_reset();
        wr(2'd2, 3'b111, 24'hC40000);
        wr(2'd1, 3'b111, 24'h84FFFF);
        wr(2'd0, 3'b111, 24'h80FFFF);
        wait_n(3);
        rd(2'd2, v);
        check("R5 ripple count", v, 32'h00C40003);
        rd(2'd1, v);
        check("R5 middle wraps", v, 32'h0084FFFF);
        check("R5 no irq from timer2", {28'h0, irq_o}, 32'h0);

        // R8: timer 0 ignores count-up
        do_reset();
        wr(2'd0, 3'b111, 24'h840010);
        wait_n(4);
        rd(2'd0, v);
        check("R8 timer0 counts anyway", v, 32'h00840014);

        // R9/R2: byte lanes and unused control bits
        do_reset();
        wr(2'd3, 3'b001, 24'hFFFF12);
        wr(2'd3, 3'b100, 24'h809999);
        rd(2'd3, v);
        check("R9 lane select", v, 32'h00800012);
        wr(2'd2, 3'b100, 24'hFF0000);
        rd(2'd2, v);
        check("R2 unused bits zero", v, 32'h00C70000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule